// File: doc/BRIEF.md
# Address-space-tagged translation cache

This block keeps a small, fully associative set of recently used virtual-to-physical page translations for a 39-bit virtual address space. A page walker writes each translation it has resolved into the refill port. The stored record holds the 27-bit virtual page number, the physical page number, the page size (4 KB, 2 MB or 1 GB), a 16-bit address-space tag, a global flag and four permission bits. A lookup presents a virtual address and the current address-space tag and gets back, in the same cycle, a hit flag, the physical address and the permission bits. The lookup path has no register in it.

A fence port removes translations after page tables change. A fence can select entries by address, by address-space tag, by both, or by neither. A fence with neither removes everything. Entries marked global are never removed by a fence that selects on the tag. Permission checking and the page walk are done outside this block.

Top module: `xlate_cache`

## Requirements
- R1: A lookup hits only if a valid entry's page number matches and either the entry's stored tag equals `lkAsid` or the entry's global flag is set.
- R2: The virtual page number is the three 9-bit fields at address bits 38:30, 29:21 and 20:12. On a hit, `lkPaddr` is the stored page number shifted up by 12 with address bits 11:0 copied below it. On a miss, `lkPaddr` and `lkPerm` read zero.
- R3: The refill level sets the page size: 0 is 4 KB, 1 is 2 MB, 2 is 1 GB. A 2 MB entry does not compare address bits 20:12. A 1 GB entry does not compare bits 29:12. The bits that are not compared replace the matching low bits of the physical address.
- R4: A fence with `flushUseAddr` and `flushUseAsid` both low invalidates every entry, taking effect from the next clock edge.
- R5: A fence with only `flushUseAddr` high invalidates every entry that maps `flushVaddr` (size-aware), whatever its tag and whatever its global flag.
- R6: A fence with only `flushUseAsid` high invalidates the non-global entries whose tag equals `flushAsid`. Global entries and entries with other tags remain.
- R7: A fence with both selectors high invalidates only the non-global entries that map `flushVaddr` and carry `flushAsid`.
- R8: While `flushValid` is high, `lkHit` is low.
- R9: After reset every entry is invalid. With `lkValid` low, `lkHit` is low.
- R10: A refill goes to the lowest-numbered invalid entry. When all 8 entries are valid, a round-robin pointer chooses the victim. The pointer starts at entry 0 after reset and advances by one each time it is used.
- R11: On a hit, `lkPerm` returns the stored permission bits {U,X,W,R}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 39 | Lookup virtual address |
| lkAsid | input | 16 | Current address-space tag |
| lkHit | output | 1 | Lookup hit |
| lkPaddr | output | 56 | Translated physical address |
| lkPerm | output | 4 | Permission bits {U,X,W,R} |
| fillValid | input | 1 | Refill write strobe |
| fillVpn | input | 27 | Refill virtual page number |
| fillPpn | input | 44 | Refill physical page number |
| fillLevel | input | 2 | Refill page size (0: 4 KB, 1: 2 MB, 2: 1 GB) |
| fillAsid | input | 16 | Refill address-space tag |
| fillGlobal | input | 1 | Refill global flag |
| fillPerm | input | 4 | Refill permission bits {U,X,W,R} |
| flushValid | input | 1 | Fence request |
| flushUseAddr | input | 1 | Fence selects by address |
| flushVaddr | input | 39 | Fence address |
| flushUseAsid | input | 1 | Fence selects by tag |
| flushAsid | input | 16 | Fence tag |

## Verification
The assertions assume that the walker never refills a translation that overlaps one already held under the same tag. Under that assumption at most one entry matches any lookup. They also assume that a refill and a fence never arrive in the same cycle, so the full-fence property can look at the following cycle without a new entry appearing there. The stimulus gives every entry a distinct top page-number field, or a distinct tag where page numbers repeat. It issues fences and refills in separate cycles, and it holds each request for exactly one cycle between falling edges.

// File: rtl/xlate_cache_pkg.sv
package xlate_cache_pkg;
  localparam int SEG_W  = 9;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = 3 * SEG_W;
  localparam int VA_W   = VPN_W + OFF_W;
  localparam int ASID_W = 16;
  localparam int PERM_W = 4;

  typedef enum logic [1:0] {
    LVL_4K = 2'd0,
    LVL_2M = 2'd1,
    LVL_1G = 2'd2
  } pageLevel_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic fillWe;
    logic flushGo;
    logic flushByAddr;
    logic flushByAsid;
  } ctrlStrobes_t;

  // size-aware page number comparison
  function automatic logic vpnHit(input logic [VPN_W-1:0] stored,
                                  input logic [VPN_W-1:0] probe,
                                  input logic [1:0]       lvl);
    logic hiEq, midEq, loEq;
    hiEq  = stored[3*SEG_W-1:2*SEG_W] == probe[3*SEG_W-1:2*SEG_W];
    midEq = stored[2*SEG_W-1:SEG_W]   == probe[2*SEG_W-1:SEG_W];
    loEq  = stored[SEG_W-1:0]         == probe[SEG_W-1:0];
    return hiEq && (lvl >= 2'd2 || midEq) && (lvl >= 2'd1 || loEq);
  endfunction
endpackage

// File: rtl/xlate_cache_ctrl.sv
module xlate_cache_ctrl
  import xlate_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fillValid,
  input  logic               flushValid,
  input  logic               flushUseAddr,
  input  logic               flushUseAsid,
  input  logic [ENTRIES-1:0] validVec,
  output ctrlStrobes_t       strobes,
  output logic [IDX_W-1:0]   victimIdx
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic             haveFree;

  // lowest-numbered invalid entry
  always_comb begin
    haveFree = 1'b0;
    freeIdx  = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (!validVec[k]) begin
        haveFree = 1'b1;
        freeIdx  = IDX_W'(k);
      end
    end
  end

  assign victimIdx = haveFree ? freeIdx : rrPtr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrPtr <= '0;
    end else if (fillValid && !haveFree) begin
      if (int'(rrPtr) == ENTRIES - 1) rrPtr <= '0;
      else                            rrPtr <= rrPtr + IDX_W'(1);
    end
  end

  always_comb begin
    strobes.fillWe      = fillValid;
    strobes.flushGo     = flushValid;
    strobes.flushByAddr = flushUseAddr;
    strobes.flushByAsid = flushUseAsid;
  end
endmodule

// File: rtl/xlate_cache_dp.sv
module xlate_cache_dp
  import xlate_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int PPN_W   = 44,
  parameter int PA_W    = PPN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       strobes,
  input  logic [IDX_W-1:0]   victimIdx,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic [1:0]         fillLevel,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic               fillGlobal,
  input  logic [PERM_W-1:0]  fillPerm,
  input  logic [VA_W-1:0]    flushVaddr,
  input  logic [ASID_W-1:0]  flushAsid,
  input  logic               lkValid,
  input  logic [VA_W-1:0]    lkVaddr,
  input  logic [ASID_W-1:0]  lkAsid,
  output logic [ENTRIES-1:0] validVec,
  output logic               lkHit,
  output logic [PA_W-1:0]    lkPaddr,
  output logic [PERM_W-1:0]  lkPerm
);
  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   vpnQ  [ENTRIES];
  logic [PPN_W-1:0]   ppnQ  [ENTRIES];
  logic [1:0]         lvlQ  [ENTRIES];
  logic [ASID_W-1:0]  asidQ [ENTRIES];
  logic               globQ [ENTRIES];
  logic [PERM_W-1:0]  permQ [ENTRIES];

  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] killVec;
  logic [PA_W-1:0]    paOf [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    logic addrSel, asidSel;
    assign lkMatch[g] = validQ[g]
                      && vpnHit(vpnQ[g], lkVaddr[VA_W-1:OFF_W], lvlQ[g])
                      && (globQ[g] || asidQ[g] == lkAsid);
    assign addrSel = !strobes.flushByAddr
                   || vpnHit(vpnQ[g], flushVaddr[VA_W-1:OFF_W], lvlQ[g]);
    assign asidSel = !strobes.flushByAsid
                   || (asidQ[g] == flushAsid && !globQ[g]);
    assign killVec[g] = strobes.flushGo && addrSel && asidSel;
    // superpage levels substitute virtual bits for the low page fields
    assign paOf[g] = {ppnQ[g][PPN_W-1:2*SEG_W],
                      (lvlQ[g] >= 2'd2) ? lkVaddr[OFF_W+2*SEG_W-1:OFF_W+SEG_W]
                                        : ppnQ[g][2*SEG_W-1:SEG_W],
                      (lvlQ[g] >= 2'd1) ? lkVaddr[OFF_W+SEG_W-1:OFF_W]
                                        : ppnQ[g][SEG_W-1:0],
                      lkVaddr[OFF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ <= '0;
    end else begin
      for (int k = 0; k < ENTRIES; k++) begin
        if (strobes.fillWe && int'(victimIdx) == k) validQ[k] <= 1'b1;
        else if (killVec[k])                        validQ[k] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < ENTRIES; k++) begin
      if (strobes.fillWe && int'(victimIdx) == k) begin
        vpnQ[k]  <= fillVpn;
        ppnQ[k]  <= fillPpn;
        lvlQ[k]  <= fillLevel;
        asidQ[k] <= fillAsid;
        globQ[k] <= fillGlobal;
        permQ[k] <= fillPerm;
      end
    end
  end

  assign validVec = validQ;
  assign lkHit    = lkValid && (|lkMatch) && !strobes.flushGo;

  always_comb begin
    lkPaddr = '0;
    lkPerm  = '0;
    if (lkHit) begin
      for (int k = 0; k < ENTRIES; k++) begin
        if (lkMatch[k]) begin
          lkPaddr = lkPaddr | paOf[k];
          lkPerm  = lkPerm  | permQ[k];
        end
      end
    end
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PPN_W   = 44,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic [ASID_W-1:0] lkAsid,
  output logic              lkHit,
  output logic [PA_W-1:0]   lkPaddr,
  output logic [PERM_W-1:0] lkPerm,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [1:0]        fillLevel,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic              fillGlobal,
  input  logic [PERM_W-1:0] fillPerm,
  input  logic              flushValid,
  input  logic              flushUseAddr,
  input  logic [VA_W-1:0]   flushVaddr,
  input  logic              flushUseAsid,
  input  logic [ASID_W-1:0] flushAsid
);
  ctrlStrobes_t       strobes;
  logic [IDX_W-1:0]   victimIdx;
  logic [ENTRIES-1:0] validVec;

  xlate_cache_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .fillValid(fillValid), .flushValid(flushValid),
    .flushUseAddr(flushUseAddr), .flushUseAsid(flushUseAsid),
    .validVec(validVec), .strobes(strobes), .victimIdx(victimIdx)
  );

  xlate_cache_dp #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .PPN_W(PPN_W), .PA_W(PA_W)) uDp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .victimIdx(victimIdx),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillLevel(fillLevel),
    .fillAsid(fillAsid), .fillGlobal(fillGlobal), .fillPerm(fillPerm),
    .flushVaddr(flushVaddr), .flushAsid(flushAsid),
    .lkValid(lkValid), .lkVaddr(lkVaddr), .lkAsid(lkAsid),
    .validVec(validVec), .lkHit(lkHit), .lkPaddr(lkPaddr), .lkPerm(lkPerm)
  );
endmodule

// File: rtl/xlate_cache_checker.sv
module xlate_cache_checker #(
  parameter int PA_W = 56
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lkValid,
  input logic [38:0]     lkVaddr,
  input logic            lkHit,
  input logic [PA_W-1:0] lkPaddr,
  input logic [3:0]      lkPerm,
  input logic            fillValid,
  input logic            flushValid,
  input logic            flushUseAddr,
  input logic            flushUseAsid
);
  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lkHit |-> lkPaddr[11:0] == lkVaddr[11:0]);

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lkHit |-> (lkPaddr == '0 && lkPerm == '0));

  p_full_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flushValid && !flushUseAddr && !flushUseAsid && !fillValid) |=> !lkHit);

  p_flush_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flushValid |-> !lkHit);

  p_idle_nohit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lkValid |-> !lkHit);
endmodule

bind xlate_cache xlate_cache_checker #(.PA_W(PA_W)) uChk (
  .clk(clk), .rst_n(rst_n), .lkValid(lkValid), .lkVaddr(lkVaddr),
  .lkHit(lkHit), .lkPaddr(lkPaddr), .lkPerm(lkPerm), .fillValid(fillValid),
  .flushValid(flushValid), .flushUseAddr(flushUseAddr), .flushUseAsid(flushUseAsid)
);

// File: tb/xlate_cache_test.sv
module xlate_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkValid = 1'b0;
  logic [38:0] lkVaddr = '0;
  logic [15:0] lkAsid = '0;
  logic        lkHit;
  logic [55:0] lkPaddr;
  logic [3:0]  lkPerm;
  logic        fillValid = 1'b0;
  logic [26:0] fillVpn = '0;
  logic [43:0] fillPpn = '0;
  logic [1:0]  fillLevel = '0;
  logic [15:0] fillAsid = '0;
  logic        fillGlobal = 1'b0;
  logic [3:0]  fillPerm = '0;
  logic        flushValid = 1'b0;
  logic        flushUseAddr = 1'b0;
  logic [38:0] flushVaddr = '0;
  logic        flushUseAsid = 1'b0;
  logic [15:0] flushAsid = '0;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xlate_cache uut (.*);

  function automatic logic [55:0] expPa(input logic [43:0] ppn, input int lvl,
                                        input logic [38:0] va);
    logic [55:0] mask;
    mask = (56'd1 << (12 + 9 * lvl)) - 56'd1;
    return ({ppn, 12'h000} & ~mask) | ({17'h0, va} & mask);
  endfunction

  task automatic fill(input logic [26:0] vpn, input logic [43:0] ppn, input int lvl,
                      input logic [15:0] asid, input bit glob, input logic [3:0] perm);
    @(negedge clk);
    fillValid = 1'b1; fillVpn = vpn; fillPpn = ppn; fillLevel = 2'(lvl);
    fillAsid = asid; fillGlobal = glob; fillPerm = perm;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic fence(input bit useA, input logic [38:0] va, input bit useS,
                       input logic [15:0] asid);
    @(negedge clk);
    flushValid = 1'b1; flushUseAddr = useA; flushVaddr = va;
    flushUseAsid = useS; flushAsid = asid;
    @(negedge clk);
    flushValid = 1'b0; flushUseAddr = 1'b0; flushUseAsid = 1'b0;
  endtask

  task automatic look(input logic [38:0] va, input logic [15:0] asid, input bit eHit,
                      input logic [55:0] ePa, input logic [3:0] ePerm, input string req);
    @(negedge clk);
    lkValid = 1'b1; lkVaddr = va; lkAsid = asid;
    #1;
    nChecks++;
    if (lkHit !== eHit || (eHit && (lkPaddr !== ePa || lkPerm !== ePerm))) begin
      nFails++;
      $display("FAIL %s: va=%h asid=%h hit=%b pa=%h perm=%h expected hit=%b pa=%h perm=%h",
               req, va, asid, lkHit, lkPaddr, lkPerm, eHit, ePa, ePerm);
    end
    lkValid = 1'b0;
  endtask

  function automatic logic [26:0] vpnOf(input int i);
    return {9'(i + 1), 9'((i * 37) & 511), 9'((i * 91 + 5) & 511)};
  endfunction
  function automatic logic [43:0] ppnOf(input int i);
    return 44'(64'h0F00000000 + 64'(i) * 64'h123457);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: empty after reset
    for (int i = 0; i < 4; i++)
      look({vpnOf(i), 12'h0}, 16'h0100, 1'b0, '0, '0, "R9 empty");
    fill(vpnOf(0), ppnOf(0), 0, 16'h0100, 1'b0, 4'h1);
    @(negedge clk); lkVaddr = {vpnOf(0), 12'h0}; lkAsid = 16'h0100; lkValid = 1'b0; #1;
    nChecks++;
    if (lkHit !== 1'b0) begin nFails++; $display("FAIL R9 idle: hit=%b expected 0", lkHit); end
    fence(1'b0, '0, 1'b0, '0);

    // fill eight entries: levels 0/1/2 rotating, entry 7 global (R1, R2, R3, R11)
    for (int i = 0; i < 8; i++)
      fill(vpnOf(i), ppnOf(i), i % 3, 16'h0100 + 16'(i & 1), i == 7, 4'(i + 1));
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 3; k++) begin
        logic [26:0] v;
        logic [38:0] va;
        v = vpnOf(i);
        if (i % 3 >= 1) v[8:0] = 9'((k * 113 + 1) & 511);
        if (i % 3 >= 2) v[17:9] = 9'((k * 71 + 3) & 511);
        va = {v, 12'((i * 677 + k * 961) & 4095)};
        look(va, 16'h0100 + 16'(i & 1), 1'b1, expPa(ppnOf(i), i % 3, va), 4'(i + 1),
             "R2/R3/R11 hit");
      end
      look({vpnOf(i), 12'h5A5}, 16'h0200, i == 7,
           expPa(ppnOf(i), i % 3, {vpnOf(i), 12'h5A5}), 4'(i + 1), "R1 tag");
    end
    // R3: compared fields must match
    look({vpnOf(0) ^ 27'h1, 12'h0}, 16'h0100, 1'b0, '0, '0, "R3 4K low field");
    look({vpnOf(3) ^ 27'h1, 12'h0}, 16'h0101, 1'b0, '0, '0, "R3 4K low field");
    look({vpnOf(1) ^ 27'h200, 12'h0}, 16'h0101, 1'b0, '0, '0, "R3 2M mid field");
    look({vpnOf(4) ^ 27'h200, 12'h0}, 16'h0100, 1'b0, '0, '0, "R3 2M mid field");

    // R10: round robin after full
    fill({9'd30, 18'h0}, 44'hAAA, 0, 16'h0100, 1'b0, 4'h3);
    look({9'd30, 18'h0, 12'h123}, 16'h0100, 1'b1, {44'hAAA, 12'h123}, 4'h3, "R10 rr fill");
    look({vpnOf(0), 12'h0}, 16'h0100, 1'b0, '0, '0, "R10 rr victim 0");
    look({vpnOf(1), 12'h0}, 16'h0101, 1'b1, expPa(ppnOf(1), 1, {vpnOf(1), 12'h0}), 4'h2, "R10 keep 1");
    fill({9'd31, 18'h0}, 44'hBBB, 0, 16'h0100, 1'b0, 4'h4);
    look({vpnOf(1), 12'h0}, 16'h0101, 1'b0, '0, '0, "R10 rr victim 1");
    // free entry 3, next refill must use it, not the pointer (entry 2)
    fence(1'b1, {vpnOf(3), 12'h0}, 1'b0, '0);
    look({vpnOf(3), 12'h0}, 16'h0101, 1'b0, '0, '0, "R5 addr only");
    fill({9'd32, 18'h0}, 44'hCCC, 0, 16'h0100, 1'b0, 4'h5);
    look({vpnOf(2), 12'h0}, 16'h0100, 1'b1, expPa(ppnOf(2), 2, {vpnOf(2), 12'h0}), 4'h3, "R10 first invalid");
    look({9'd32, 18'h0, 12'h0}, 16'h0100, 1'b1, {44'hCCC, 12'h0}, 4'h5, "R10 first invalid");

    // R4: full fence
    fence(1'b0, '0, 1'b0, '0);
    for (int i = 2; i < 8; i++)
      look({vpnOf(i), 12'h0}, 16'h0100 + 16'(i & 1), 1'b0, '0, '0, "R4 all gone");

    // selective fences: A tag5, B same page tag6, G global 1G, C tag5
    for (int pass = 0; pass < 3; pass++) begin
      fence(1'b0, '0, 1'b0, '0);
      fill({9'd1, 9'd2, 9'd3}, 44'h111, 0, 16'd5, 1'b0, 4'h1);
      fill({9'd1, 9'd2, 9'd3}, 44'h222, 0, 16'd6, 1'b0, 4'h2);
      fill({9'd2, 18'h0},      44'h333, 2, 16'd5, 1'b1, 4'h3);
      fill({9'd3, 9'd4, 9'd5}, 44'h444, 0, 16'd5, 1'b0, 4'h4);
      if (pass == 0) begin
        fence(1'b1, {9'd1, 9'd2, 9'd3, 12'h0}, 1'b0, 16'd5);
        look({9'd1, 9'd2, 9'd3, 12'h0}, 16'd5, 1'b0, '0, '0, "R5 tag5 gone");
        look({9'd1, 9'd2, 9'd3, 12'h0}, 16'd6, 1'b0, '0, '0, "R5 tag6 gone");
        look({9'd3, 9'd4, 9'd5, 12'h7}, 16'd5, 1'b1, {44'h444, 12'h7}, 4'h4, "R5 other kept");
        fence(1'b1, {9'd2, 9'd77, 9'd9, 12'h0}, 1'b0, '0);
        look({9'd2, 9'd8, 9'd1, 12'h0}, 16'd5, 1'b0, '0, '0, "R5 global by addr");
      end else if (pass == 1) begin
        fence(1'b0, '0, 1'b1, 16'd5);
        look({9'd1, 9'd2, 9'd3, 12'h0}, 16'd5, 1'b0, '0, '0, "R6 tag5 gone");
        look({9'd3, 9'd4, 9'd5, 12'h0}, 16'd5, 1'b0, '0, '0, "R6 tag5 gone");
        look({9'd1, 9'd2, 9'd3, 12'h9}, 16'd6, 1'b1, {44'h222, 12'h9}, 4'h2, "R6 tag6 kept");
        look({9'd2, 9'd8, 9'd1, 12'h1}, 16'd5, 1'b1,
             expPa(44'h333, 2, {9'd2, 9'd8, 9'd1, 12'h1}), 4'h3, "R6 global kept");
      end else begin
        fence(1'b1, {9'd1, 9'd2, 9'd3, 12'h0}, 1'b1, 16'd5);
        look({9'd1, 9'd2, 9'd3, 12'h0}, 16'd5, 1'b0, '0, '0, "R7 both gone");
        look({9'd1, 9'd2, 9'd3, 12'h0}, 16'd6, 1'b1, {44'h222, 12'h0}, 4'h2, "R7 tag6 kept");
        look({9'd3, 9'd4, 9'd5, 12'h0}, 16'd5, 1'b1, {44'h444, 12'h0}, 4'h4, "R7 other page kept");
        fence(1'b1, {9'd2, 27'h0, 3'h0}, 1'b1, 16'd5);
        look({9'd2, 9'd8, 9'd1, 12'h1}, 16'd5, 1'b1,
             expPa(44'h333, 2, {9'd2, 9'd8, 9'd1, 12'h1}), 4'h3, "R7 global kept");
      end
    end

    // R8: lookup during an unrelated fence reports miss, entry survives
    @(negedge clk);
    flushValid = 1'b1; flushUseAddr = 1'b1; flushVaddr = {9'd99, 30'h0}; flushUseAsid = 1'b0;
    lkValid = 1'b1; lkVaddr = {9'd3, 9'd4, 9'd5, 12'h0}; lkAsid = 16'd5;
    #1;
    nChecks++;
    if (lkHit !== 1'b0) begin nFails++; $display("FAIL R8: hit=%b expected 0", lkHit); end
    @(negedge clk);
    flushValid = 1'b0; flushUseAddr = 1'b0; lkValid = 1'b0;
    look({9'd3, 9'd4, 9'd5, 12'h0}, 16'd5, 1'b1, {44'h444, 12'h0}, 4'h4, "R8 survivor");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule